// File: doc/BRIEF.md
# Floating-Point Status and Control Register

This block holds the 64-bit status and control word of a processor floating-point unit. Bits are numbered MSB-0 in the field descriptions below; the port `csr_o` is an ordinary `[63:0]` vector, so MSB-0 bit n appears at `csr_o[63-n]`. The word carries a decimal rounding mode, a binary rounding mode, sticky exception flags, nine invalid-operation cause flags, five exception enables, a non-IEEE mode bit, and a five-bit result-class field.

Three update paths can change the word:

- **Full write.** Replaces the whole register.
- **Masked write.** Replaces only the selected bits.
- **Sticky set pulses.** An execution unit raises these to set individual exception flags.

A fourth path loads the result-class field. It takes a double-precision result and classifies it with a built-in helper. The helper's five-bit code is also visible combinationally, so the execution pipeline can use it directly.

After every update, two summary bits are recomputed from the other fields:

- the invalid-operation summary;
- the enabled-exception summary.

The overall exception summary bit is never derived. It moves only when a write targets it.

Top module: `fp_status_reg`

## Requirements
- R1: After reset is asserted, the register reads all zeros. This means round-to-nearest, no flags set, and all exceptions disabled.
- R2: A full write (`wr_full_i`) loads `wr_data_i`, with these exceptions:
  - The reserved bits always read zero. These are MSB-0 bits 0..28 and 52, which are `csr_o[63:35]` and `csr_o[11]`.
  - The two summary bits follow R5 and R6.
- R3: A masked write (`mask_we_i`) changes only the bits selected by `mask_i`. Those bits take their value from `mask_data_i`. Every other bit keeps its value.
- R4: Bit i of `sticky_set_i` ORs a 1 into the flag at the position listed below. A pulse never clears a flag. A cycle without pulses leaves the flags unchanged.

  | `sticky_set_i` bit | Flag | MSB-0 bit | `csr_o` index |
  |---|---|---|---|
  | 0 | overflow | 35 | 28 |
  | 1 | underflow | 36 | 27 |
  | 2 | zero-divide | 37 | 26 |
  | 3 | inexact | 38 | 25 |
  | 4..9 | invalid causes | 39..44 | 24..19 |
  | 10..12 | invalid causes | 53..55 | 10..8 |
- R5: The invalid summary bit is MSB-0 bit 34, which is `csr_o[29]`. It always equals the OR of the nine invalid-cause bits. A value written directly to this bit is replaced by the recomputed value in the same cycle.
- R6: The enabled summary bit is MSB-0 bit 33, which is `csr_o[30]`. It always equals the OR of five flag-and-enable pairs:
  - invalid summary AND invalid enable (`csr_o[7]`);
  - overflow AND its enable (`csr_o[6]`);
  - underflow AND its enable (`csr_o[5]`);
  - zero-divide AND its enable (`csr_o[4]`);
  - inexact AND its enable (`csr_o[3]`).

  A value written directly to this bit is replaced by the recomputed value.
- R7: The exception summary bit is MSB-0 bit 32, which is `csr_o[31]`. It changes only through a full write or a masked write that selects it. Sticky pulses never set it.
- R8: Same-cycle priority works as follows:
  - A full write overrides a masked write and a class load.
  - A class load (`cls_we_i`) overrides a masked write on the class field.
  - Sticky pulses OR in after all writes.
- R9: `class_flags_o` encodes `cls_val_i` as {C,FL,FG,FE,FU}:
  - quiet NaN: 10001
  - -infinity: 01001
  - -normal: 01000
  - -denormal: 11000
  - +denormal: 10100
  - +normal: 00100
  - +infinity: 00101

  A class load writes this code into MSB-0 bits 47..51, which are `csr_o[16:12]`, with C at `csr_o[16]`.
- R10: The class code for -zero is 10010 and for +zero is 00010. A signalling NaN gives the same code as a quiet NaN, 10001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_full_i | input | 1 | Full-register write strobe |
| wr_data_i | input | 64 | Full-write data |
| mask_we_i | input | 1 | Masked-write strobe |
| mask_i | input | 64 | Bit select for the masked write |
| mask_data_i | input | 64 | Masked-write data |
| sticky_set_i | input | 13 | Sticky flag set pulses (order listed in R4) |
| cls_we_i | input | 1 | Load the class code of `cls_val_i` into the class field |
| cls_val_i | input | 64 | Double-precision result to classify |
| csr_o | output | 64 | Register contents |
| class_flags_o | output | 5 | Combinational class code of `cls_val_i` |

## Verification
The summary logic is tested with three kinds of pattern:

- Writes that force the summary bits on while every cause bit is clear. These separate recomputation from storage.
- Single cause bits written with and without their enable, one pair at a time. These separate each term of the enabled-summary OR.
- A sticky pulse with no enable set. This separates cause updates from the enables.

The classifier is tried on each sign of zero, denormal, normal, the largest normal, and infinity, and on both NaN kinds. This separates the exponent test from the mantissa test, and the sign handling from both.

Coincident updates show three things:

- which write path wins when writes coincide;
- that sticky pulses survive a same-cycle full write;
- that a class load wins over a masked write on the class field.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  localparam int unsigned REG_W    = 64;
  localparam int unsigned N_STICKY = 13;
  localparam int unsigned CLS_W    = 5;

  // LSB-0 indices (MSB-0 position n maps to REG_W-1-n)
  localparam int unsigned FX_B   = 31;
  localparam int unsigned FEX_B  = 30;
  localparam int unsigned VX_B   = 29;
  localparam int unsigned OX_B   = 28;
  localparam int unsigned UX_B   = 27;
  localparam int unsigned ZX_B   = 26;
  localparam int unsigned XX_B   = 25;
  localparam int unsigned VE_B   = 7;
  localparam int unsigned OE_B   = 6;
  localparam int unsigned UE_B   = 5;
  localparam int unsigned ZE_B   = 4;
  localparam int unsigned XE_B   = 3;
  localparam int unsigned CLS_LO = 12;
  localparam int unsigned CLS_HI = CLS_LO + CLS_W - 1;

  localparam logic [REG_W-1:0] RSV_MASK = 64'hFFFF_FFF8_0000_0800;
  localparam logic [REG_W-1:0] INV_MASK = 64'h0000_0000_01F8_0700;

  typedef logic [CLS_W-1:0] cls_code_t;
  localparam cls_code_t CLS_QNAN  = 5'b10001;
  localparam cls_code_t CLS_NINF  = 5'b01001;
  localparam cls_code_t CLS_NNORM = 5'b01000;
  localparam cls_code_t CLS_NDEN  = 5'b11000;
  localparam cls_code_t CLS_NZERO = 5'b10010;
  localparam cls_code_t CLS_PZERO = 5'b00010;
  localparam cls_code_t CLS_PDEN  = 5'b10100;
  localparam cls_code_t CLS_PNORM = 5'b00100;
  localparam cls_code_t CLS_PINF  = 5'b00101;

  // sticky pulse index -> register bit
  function automatic int unsigned sticky_pos(int unsigned idx);
    int unsigned p;
    if (idx < 4)       p = OX_B - idx;        // OX UX ZX XX
    else if (idx < 10) p = 24 - (idx - 4);    // first six invalid causes
    else               p = 10 - (idx - 10);   // last three invalid causes
    return p;
  endfunction
endpackage

// File: rtl/fpsr_classify.sv
module fpsr_classify
  import fpsr_pkg::*;
#(
  parameter int unsigned EXP_W = 11,
  parameter int unsigned MAN_W = 52,
  localparam int unsigned VAL_W = EXP_W + MAN_W + 1
) (
  input  logic [VAL_W-1:0] val_i,
  output cls_code_t        code_o
);
  logic             sgn;
  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] man;
  logic             ex_max, ex_zero, man_zero;

  assign sgn      = val_i[VAL_W-1];
  assign ex       = val_i[VAL_W-2 -: EXP_W];
  assign man      = val_i[MAN_W-1:0];
  assign ex_max   = &ex;
  assign ex_zero  = ~|ex;
  assign man_zero = ~|man;

  always_comb begin
    if (ex_max && !man_zero)      code_o = CLS_QNAN;
    else if (ex_max)              code_o = sgn ? CLS_NINF  : CLS_PINF;
    else if (ex_zero && man_zero) code_o = sgn ? CLS_NZERO : CLS_PZERO;
    else if (ex_zero)             code_o = sgn ? CLS_NDEN  : CLS_PDEN;
    else                          code_o = sgn ? CLS_NNORM : CLS_PNORM;
  end
endmodule

// File: rtl/fpsr_sticky_map.sv
module fpsr_sticky_map
  import fpsr_pkg::*;
#(
  parameter int unsigned N = N_STICKY
) (
  input  logic [N-1:0]     pulse_i,
  output logic [REG_W-1:0] set_mask_o
);
  logic [REG_W-1:0] lane [N];

  for (genvar g = 0; g < N; g++) begin : g_lane
    localparam int unsigned POS = sticky_pos(g);
    assign lane[g] = {{(REG_W-1){1'b0}}, pulse_i[g]} << POS;
  end

  always_comb begin
    set_mask_o = '0;
    for (int i = 0; i < N; i++) set_mask_o = set_mask_o | lane[i];
  end
endmodule

// File: rtl/fpsr_summary.sv
module fpsr_summary
  import fpsr_pkg::*;
(
  input  logic [REG_W-1:0] raw_i,
  output logic [REG_W-1:0] fixed_o
);
  logic vx, fex;

  assign vx  = |(raw_i & INV_MASK);
  assign fex = (vx          & raw_i[VE_B]) |
               (raw_i[OX_B] & raw_i[OE_B]) |
               (raw_i[UX_B] & raw_i[UE_B]) |
               (raw_i[ZX_B] & raw_i[ZE_B]) |
               (raw_i[XX_B] & raw_i[XE_B]);

  always_comb begin
    fixed_o         = raw_i & ~RSV_MASK;
    fixed_o[VX_B]   = vx;
    fixed_o[FEX_B]  = fex;
  end
endmodule

// File: rtl/fp_status_reg.sv
module fp_status_reg
  import fpsr_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_full_i,
  input  logic [REG_W-1:0]    wr_data_i,
  input  logic                mask_we_i,
  input  logic [REG_W-1:0]    mask_i,
  input  logic [REG_W-1:0]    mask_data_i,
  input  logic [N_STICKY-1:0] sticky_set_i,
  input  logic                cls_we_i,
  input  logic [REG_W-1:0]    cls_val_i,
  output logic [REG_W-1:0]    csr_o,
  output logic [CLS_W-1:0]    class_flags_o
);
  logic [REG_W-1:0] csr_q, merged, set_mask, nxt;
  cls_code_t        cls_code;

  fpsr_classify #(.EXP_W(11), .MAN_W(52)) i_classify (
    .val_i (cls_val_i),
    .code_o(cls_code)
  );

  fpsr_sticky_map #(.N(N_STICKY)) i_sticky_map (
    .pulse_i   (sticky_set_i),
    .set_mask_o(set_mask)
  );

  // priority: full > class load > masked; sticky ORs last
  always_comb begin
    merged = csr_q;
    if (mask_we_i) merged = (merged & ~mask_i) | (mask_data_i & mask_i);
    if (cls_we_i)  merged[CLS_HI:CLS_LO] = cls_code;
    if (wr_full_i) merged = wr_data_i;
    merged = merged | set_mask;
  end

  fpsr_summary i_summary (
    .raw_i  (merged),
    .fixed_o(nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) csr_q <= '0;
    else         csr_q <= nxt;
  end

  assign csr_o         = csr_q;
  assign class_flags_o = cls_code;
endmodule

// File: rtl/fp_status_reg_chk.sv
module fp_status_reg_chk
  import fpsr_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_full_i,
  input logic                mask_we_i,
  input logic [REG_W-1:0]    mask_i,
  input logic [N_STICKY-1:0] sticky_set_i,
  input logic                cls_we_i,
  input logic [REG_W-1:0]    csr_o,
  input logic [CLS_W-1:0]    class_flags_o
);
  a_r2_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_o & RSV_MASK) == '0);

  a_r5_vx_summary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_o[VX_B] == |(csr_o & INV_MASK));

  a_r6_fex_summary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_o[FEX_B] == ((csr_o[VX_B] & csr_o[VE_B]) | (csr_o[OX_B] & csr_o[OE_B]) |
                     (csr_o[UX_B] & csr_o[UE_B]) | (csr_o[ZX_B] & csr_o[ZE_B]) |
                     (csr_o[XX_B] & csr_o[XE_B])));

  a_r4_sticky_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sticky_set_i[0] |=> csr_o[OX_B]);

  a_r7_fx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_full_i && !(mask_we_i && mask_i[FX_B])) |=> $stable(csr_o[FX_B]));

  a_r8_class_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls_we_i && !wr_full_i) |=> csr_o[CLS_HI:CLS_LO] == $past(class_flags_o));
endmodule

bind fp_status_reg fp_status_reg_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_full_i    (wr_full_i),
  .mask_we_i    (mask_we_i),
  .mask_i       (mask_i),
  .sticky_set_i (sticky_set_i),
  .cls_we_i     (cls_we_i),
  .csr_o        (csr_o),
  .class_flags_o(class_flags_o)
);

// File: tb/test_fp_status_reg.sv
`timescale 1ns/1ps
module test_fp_status_reg;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_full_i = 1'b0;
  logic [63:0] wr_data_i = '0;
  logic        mask_we_i = 1'b0;
  logic [63:0] mask_i = '0;
  logic [63:0] mask_data_i = '0;
  logic [12:0] sticky_set_i = '0;
  logic        cls_we_i = 1'b0;
  logic [63:0] cls_val_i = '0;
  logic [63:0] csr_o;
  logic [4:0]  class_flags_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fp_status_reg i_fp_status_reg (
    .clk_i(clk), .rst_ni(rst_ni), .wr_full_i(wr_full_i), .wr_data_i(wr_data_i),
    .mask_we_i(mask_we_i), .mask_i(mask_i), .mask_data_i(mask_data_i),
    .sticky_set_i(sticky_set_i), .cls_we_i(cls_we_i), .cls_val_i(cls_val_i),
    .csr_o(csr_o), .class_flags_o(class_flags_o)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle();
    wr_full_i = 0; mask_we_i = 0; mask_i = '0; mask_data_i = '0;
    sticky_set_i = '0; cls_we_i = 0;
  endtask

  // inputs set after a negedge; registered result is sampled at the next negedge
  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic full(input logic [63:0] d);
    wr_full_i = 1; wr_data_i = d; step();
  endtask

  task automatic t_reset();
    chk("R1 reset value", csr_o, 64'h0);
  endtask

  task automatic t_full_write();
    full('1);
    chk("R2 all-ones write masks reserved", csr_o, 64'h0000_0007_FFFF_F7FF);
    full(64'h0);
    chk("R2 zero write", csr_o, 64'h0);
  endtask

  task automatic t_summaries();
    full(64'h6000_0000);
    chk("R5 R6 forced summaries recomputed to zero", csr_o, 64'h0);
    full(64'h0000_0100);
    chk("R5 one cause sets VX, no enable", csr_o, 64'h2000_0100);
    full(64'h0000_0180);
    chk("R6 cause with invalid enable", csr_o, 64'h6000_0180);
    for (int i = 0; i < 4; i++) begin
      full(64'h1 << (28 - i));
      chk("R6 flag without enable", csr_o, 64'h1 << (28 - i));
      full((64'h1 << (28 - i)) | (64'h1 << (6 - i)));
      chk("R6 flag with enable", csr_o, (64'h1 << (28 - i)) | (64'h1 << (6 - i)) | 64'h4000_0000);
      full(64'h1 << (6 - i));
      chk("R6 enable alone", csr_o, 64'h1 << (6 - i));
    end
  endtask

  task automatic t_masked();
    full(64'h0000_0004_0000_0003);
    mask_we_i = 1; mask_i = 64'h3; mask_data_i = 64'h1; step();
    chk("R3 masked write of rounding bits", csr_o, 64'h0000_0004_0000_0001);
    mask_we_i = 1; mask_i = 64'hFFFF_0000_0000_0000; mask_data_i = '1; step();
    chk("R3 R2 masked write to reserved bits", csr_o, 64'h0000_0004_0000_0001);
  endtask

  task automatic t_sticky();
    full(64'h0);
    sticky_set_i = 13'h0001; step();
    chk("R4 overflow pulse, R7 FX untouched", csr_o, 64'h1000_0000);
    sticky_set_i = 13'h1000; step();
    chk("R4 R5 last invalid cause pulse", csr_o, 64'h3000_0100);
    step();
    chk("R4 flags held with no pulse", csr_o, 64'h3000_0100);
    sticky_set_i = 13'h0001; step();
    chk("R4 repeated pulse keeps flag", csr_o, 64'h3000_0100);
    full(64'h0);
    sticky_set_i = 13'h0010; step();
    chk("R4 first invalid cause position", csr_o, 64'h2100_0000);
  endtask

  task automatic t_fx();
    full(64'h0);
    mask_we_i = 1; mask_i = 64'h8000_0000; mask_data_i = 64'h8000_0000; step();
    chk("R7 FX set by masked write", csr_o, 64'h8000_0000);
    sticky_set_i = '0; step(); step();
    chk("R7 FX holds", csr_o, 64'h8000_0000);
    mask_we_i = 1; mask_i = 64'h8000_0000; mask_data_i = 64'h0; step();
    chk("R7 FX cleared by masked write", csr_o, 64'h0);
  endtask

  task automatic t_priority();
    wr_full_i = 1; wr_data_i = 64'h1;
    mask_we_i = 1; mask_i = 64'h3; mask_data_i = 64'h2; step();
    chk("R8 full write beats masked", csr_o, 64'h1);
    wr_full_i = 1; wr_data_i = 64'h0; sticky_set_i = 13'h0002; step();
    chk("R8 sticky survives full write", csr_o, 64'h0800_0000);
    full(64'h0);
    mask_we_i = 1; mask_i = 64'h1F000; mask_data_i = 64'h0;
    cls_we_i = 1; cls_val_i = 64'h7FF0_0000_0000_0000; step();
    chk("R8 class load beats masked", csr_o, 64'h5000);
  endtask

  task automatic one_cls(input string req, input logic [63:0] v, input logic [4:0] e);
    cls_val_i = v; #1;
    chk(req, {59'h0, class_flags_o}, {59'h0, e});
  endtask

  task automatic t_classify();
    one_cls("R9 quiet NaN",  64'h7FF8_0000_0000_0000, 5'b10001);
    one_cls("R10 signalling NaN", 64'h7FF0_0000_0000_0001, 5'b10001);
    one_cls("R9 -inf",       64'hFFF0_0000_0000_0000, 5'b01001);
    one_cls("R9 +inf",       64'h7FF0_0000_0000_0000, 5'b00101);
    one_cls("R9 -normal",    64'hBFF0_0000_0000_0000, 5'b01000);
    one_cls("R9 +normal",    64'h3FF0_0000_0000_0000, 5'b00100);
    one_cls("R9 max normal", 64'h7FEF_FFFF_FFFF_FFFF, 5'b00100);
    one_cls("R9 -denormal",  64'h8000_0000_0000_0001, 5'b11000);
    one_cls("R9 +denormal",  64'h0000_0000_0000_0001, 5'b10100);
    one_cls("R10 -zero",     64'h8000_0000_0000_0000, 5'b10010);
    one_cls("R10 +zero",     64'h0,                   5'b00010);
    full(64'h0);
    cls_we_i = 1; cls_val_i = 64'h8000_0000_0000_0001; step();
    chk("R9 class load into field", csr_o, 64'h1_8000);
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_write();
    t_summaries();
    t_masked();
    t_sticky();
    t_fx();
    t_priority();
    t_classify();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule